// File: doc/BRIEF.md
# Burst-Write Interrupt Sequencer

This block sits on the controller side of a DDR graphics memory and runs one burst write at a time. A requester hands it a bank, a column and a stream of write beats. The block then issues the write command and opens the data bus. It drives each beat while the mask is held low, and it closes the bus when the burst ends. The model is single data rate: one beat per clock.

While the burst is running, the sequencer can take an interrupt that cuts the burst short. The interrupt is either a read to any bank or a precharge of the bank being written. Beats already on the bus when the interrupt is accepted are committed. Every later beat slot of the burst carries the mask and no data. The interrupting command then waits for its recovery gap. A read waits for the write-to-read gap and a precharge waits for the write-recovery gap. A new write to another column of the open bank restarts the burst with no precharge.

Requests use ready/valid. A request is taken in a cycle where both its request and its ready are high. Ready drops for as long as a taken interrupt is still waiting for its gap, and for as long as read data owns the bus.

Top module: `wrburst_seq`

## Requirements
- R1: A write taken in cycle A puts WRITE (cmd code 2'b01) with its bank and column on the command outputs in cycle A+1. Beats 0..BL-1 then follow in cycles A+2..A+BL+1. In those cycles dq_oe and wd_take are high, dm is all zero, wd_beat gives the beat index and dq_out carries wd_data.
- R2: When no interrupt comes, all BL beats are driven unmasked. After the burst the block is idle: dq_oe is low, dm is zero, cmd is NOP (2'b00) and wr_ready is high.
- R3: A read to any bank can be taken in any burst cycle from the WRITE cycle through the last beat. Beats driven up to and including the taking cycle are committed. Every later beat slot of that burst has all dm bits high and dq_oe low.
- R4: A read taken in cycle I appears as READ (2'b10) with its bank and column in cycle I+T_WTR+1. This is at least T_WTR cycles after the last written beat.
- R5: dq_oe is low in the READ cycle and in every cycle after it until the first read data beat, which comes CL=2 cycles after READ. The last driven beat is therefore no later than the READ cycle.
- R6: A precharge to the bank being written, taken in cycle I, masks the rest of the burst in the same way as a read. It appears as PRECHARGE (2'b11) with that bank in cycle I+T_WR+1.
- R7: A precharge to any other bank is not taken: pre_ready is low. The burst completes unmasked and no PRECHARGE is issued.
- R8: From the cycle after an interrupt is taken until its command issues, rd_ready, pre_ready and wr_ready are low. After READ in cycle R, wr_ready stays low through cycle R+CL+BL-2 and is high again in cycle R+CL+BL-1.
- R9: A write to the open bank taken during an unmasked burst in cycle I cuts the old beat stream after cycle I. It issues WRITE in cycle I+1 and drives beats 0..BL-1 again from cycle I+2. A write to another bank during a burst is not taken: wr_ready is low.
- R10: When requests collide in one cycle, a read wins over a precharge and both win over a write. Only one of them is taken.
- R11: While reset is low, cmd is NOP, dq_oe is low, dm is zero, wr_ready is high, and rd_ready and pre_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_bank | input | BANK_W | Write bank |
| wr_col | input | COL_W | Write start column |
| wr_ready | output | 1 | Write can be taken this cycle |
| rd_req | input | 1 | Interrupting read request |
| rd_bank | input | BANK_W | Read bank (any) |
| rd_col | input | COL_W | Read column |
| rd_ready | output | 1 | Read interrupt can be taken |
| pre_req | input | 1 | Interrupting precharge request |
| pre_bank | input | BANK_W | Bank to precharge |
| pre_ready | output | 1 | Precharge can be taken (same bank only) |
| wd_data | input | DQ_W | Write data for the beat named by wd_beat |
| wd_take | output | 1 | A write beat is driven this cycle |
| wd_beat | output | BEAT_W | Index of the current beat slot |
| cmd | output | 2 | Command: 00 NOP, 01 WRITE, 10 READ, 11 PRECHARGE |
| cmd_bank | output | BANK_W | Command bank |
| cmd_col | output | COL_W | Command column |
| dq_out | output | DQ_W | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dm | output | DQ_W/8 | Per-byte data mask |

## Verification
Two functions can meet in one cycle. One is the arbiter choosing among a read, a same-bank precharge and a same-bank write. The other is an interrupt landing on the last beat slot, so the masking and the natural end of the burst happen on the same edge. The bench raises a read and a precharge in the same burst cycle and expects exactly one READ, no PRECHARGE and pre_ready low. It also raises a read in the final beat slot and expects all eight beats committed, no masked slot and the READ at the computed gap. Each case is judged from per-cycle records of the ports, compared against cycle offsets worked out from the parameters.

// File: rtl/wrseq_pkg.sv
package wrseq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_PRE   = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'b00,
    PEND_RD   = 2'b01,
    PEND_PRE  = 2'b10
  } pend_e;

  // Counter preload so that a command issues (t + 1) cycles after the
  // interrupt is taken: busy for t cycles, issue on the expiring edge.
  function automatic int gap_load(int t);
    return (t < 1) ? 0 : t - 1;
  endfunction

  // Cycles after READ during which read data owns the bus (minus the
  // expiring cycle): read data spans cycles R+cl .. R+cl+bl-1.
  function automatic int hold_load(int cl, int bl);
    return cl + bl - 2;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wrseq_downcnt.sv
module wrseq_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         expire
);

  logic [W-1:0] cnt_q;
  logic         busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

  assert_expire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !busy);

endmodule

// File: rtl/wrseq_beat_ctr.sv
module wrseq_beat_ctr #(
  parameter int BL     = 8,
  parameter int SLOT_W = $clog2(BL + 1),
  parameter int BEAT_W = $clog2(BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cut,
  output logic              act,
  output logic              data_slot,
  output logic              masked,
  output logic [BEAT_W-1:0] beat_idx
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BL);

  logic [SLOT_W-1:0] slot_q;
  logic              act_q;
  logic              mask_q;

  // slot 0 is the WRITE command cycle; slots 1..BL carry beats 0..BL-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      act_q  <= 1'b0;
      mask_q <= 1'b0;
    end else if (start) begin
      slot_q <= '0;
      act_q  <= 1'b1;
      mask_q <= 1'b0;
    end else if (act_q) begin
      if (slot_q == LAST) begin
        act_q  <= 1'b0;
        mask_q <= 1'b0;
      end else begin
        slot_q <= slot_q + 1'b1;
        if (cut) mask_q <= 1'b1;
      end
    end
  end

  assign act       = act_q;
  assign masked    = mask_q;
  assign data_slot = act_q && (slot_q != '0);
  assign beat_idx  = BEAT_W'(slot_q - 1'b1);

  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (slot_q <= LAST));

  assert_mask_only_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> act);

endmodule

// File: rtl/wrburst_seq.sv
module wrburst_seq
  import wrseq_pkg::*;
#(
  parameter int DQ_W   = 32,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int BL     = 8,
  parameter int CL     = 2,
  parameter int T_WTR  = 2,
  parameter int T_WR   = 3,
  parameter int BEAT_W = $clog2(BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [COL_W-1:0]  wr_col,
  output logic              wr_ready,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  output logic              rd_ready,
  input  logic              pre_req,
  input  logic [BANK_W-1:0] pre_bank,
  output logic              pre_ready,
  input  logic [DQ_W-1:0]   wd_data,
  output logic              wd_take,
  output logic [BEAT_W-1:0] wd_beat,
  output logic [1:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [DQ_W/8-1:0] dm
);

  localparam int NLANE  = DQ_W / 8;
  localparam int SLOT_W = $clog2(BL + 1);
  localparam int MAXT   = max3(T_WTR, T_WR, CL + BL);
  localparam int TW     = $clog2(MAXT + 1);
  localparam logic [TW-1:0] LD_WTR  = TW'(gap_load(T_WTR));
  localparam logic [TW-1:0] LD_WR   = TW'(gap_load(T_WR));
  localparam logic [TW-1:0] LD_HOLD = TW'(hold_load(CL, BL));

  // ---------------- named internal events ----------------
  logic b_act, b_data, b_masked;
  logic g_busy, g_expire, g_load;
  logic h_busy, h_expire, h_load;
  logic can_int, pre_hit, wr_ok;
  logic rd_acc, pre_acc, wr_acc, int_acc, issue;
  logic [TW-1:0] g_val;

  pend_e              pend_q;
  logic [BANK_W-1:0]  pbank_q, cur_bank_q;
  logic [COL_W-1:0]   pcol_q;
  cmd_e               cmd_q;
  logic [BANK_W-1:0]  cmd_bank_q;
  logic [COL_W-1:0]   cmd_col_q;

  // ---------------- beat slot tracking ----------------
  wrseq_beat_ctr #(
    .BL(BL), .SLOT_W(SLOT_W), .BEAT_W(BEAT_W)
  ) u_beat (
    .clk(clk), .rst_n(rst_n),
    .start(wr_acc), .cut(int_acc),
    .act(b_act), .data_slot(b_data), .masked(b_masked),
    .beat_idx(wd_beat)
  );

  // ---------------- gap timer (tWTR / tWR) ----------------
  wrseq_downcnt #(.W(TW)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(g_load), .load_val(g_val),
    .busy(g_busy), .expire(g_expire)
  );

  // ---------------- read-data bus hold ----------------
  wrseq_downcnt #(.W(TW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(h_load), .load_val(LD_HOLD),
    .busy(h_busy), .expire(h_expire)
  );

  // ---------------- acceptance and priority ----------------
  always_comb begin
    can_int   = b_act && !b_masked && (pend_q == PEND_NONE);
    pre_hit   = (pre_bank == cur_bank_q);
    rd_ready  = can_int;
    pre_ready = can_int && !rd_req && pre_hit;
    wr_ok     = (pend_q == PEND_NONE) && !h_busy &&
                (!b_act || (!b_masked && (wr_bank == cur_bank_q)));
    rd_acc    = rd_req && rd_ready;
    pre_acc   = pre_req && pre_ready;
    wr_ready  = wr_ok && !rd_acc && !pre_acc;
    wr_acc    = wr_req && wr_ready;
    int_acc   = rd_acc || pre_acc;
    g_load    = int_acc;
    g_val     = rd_acc ? LD_WTR : LD_WR;
    issue     = (pend_q != PEND_NONE) && g_expire;
    h_load    = issue && (pend_q == PEND_RD);
  end

  // ---------------- pending interrupt ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= PEND_NONE;
      pbank_q <= '0;
      pcol_q  <= '0;
    end else if (int_acc) begin
      pend_q  <= rd_acc ? PEND_RD : PEND_PRE;
      pbank_q <= rd_acc ? rd_bank : cur_bank_q;
      pcol_q  <= rd_acc ? rd_col : '0;
    end else if (issue) begin
      pend_q  <= PEND_NONE;
    end
  end

  // ---------------- command register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= CMD_NOP;
      cmd_bank_q <= '0;
      cmd_col_q  <= '0;
      cur_bank_q <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      if (wr_acc) begin
        cmd_q      <= CMD_WRITE;
        cmd_bank_q <= wr_bank;
        cmd_col_q  <= wr_col;
        cur_bank_q <= wr_bank;
      end else if (issue) begin
        cmd_q      <= (pend_q == PEND_RD) ? CMD_READ : CMD_PRE;
        cmd_bank_q <= pbank_q;
        cmd_col_q  <= pcol_q;
      end
    end
  end

  // ---------------- outputs ----------------
  assign cmd      = cmd_q;
  assign cmd_bank = cmd_bank_q;
  assign cmd_col  = cmd_col_q;
  assign wd_take  = b_data && !b_masked;
  assign dq_oe    = wd_take;
  assign dq_out   = wd_take ? wd_data : '0;
  assign dm       = {NLANE{b_data && b_masked}};

  // ---------------- assertions ----------------
  assert_cut_releases_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_acc |=> !dq_oe);

  assert_cmd_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ || cmd_q == CMD_PRE) |-> $past(g_expire));

  assert_read_bus_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ) |-> !dq_oe);

  assert_read_bus_idle_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ) |=> !dq_oe);

  assert_pre_same_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (cmd_bank_q == cur_bank_q));

  assert_read_stalls_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ) |=> !wr_ready);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_expire && !b_act && pend_q == PEND_NONE && !g_busy) |=> wr_ready);

  assert_single_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_acc, pre_acc, wr_acc}));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_act) |-> (!dq_oe && dm == '0));

endmodule

// File: tb/wrburst_seq_tb.sv
`timescale 1ns/1ps
module wrburst_seq_tb;
  import wrseq_pkg::*;

  localparam int DQ_W = 32, BANK_W = 2, COL_W = 8, BL = 8, CL = 2;
  localparam int T_WTR = 2, T_WR = 3, NREL = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 0, rd_req = 0, pre_req = 0;
  logic [BANK_W-1:0] wr_bank = '0, rd_bank = '0, pre_bank = '0;
  logic [COL_W-1:0]  wr_col = '0, rd_col = '0;
  logic wr_ready, rd_ready, pre_ready, wd_take, dq_oe;
  logic [2:0] wd_beat;
  logic [DQ_W-1:0] wd_data, dq_out;
  logic [1:0] cmd;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0] cmd_col;
  logic [DQ_W/8-1:0] dm;

  always #10 clk = ~clk;

  assign wd_data = 32'hC0DE_0000 | 32'(wd_beat);

  wrburst_seq #(.DQ_W(DQ_W), .BANK_W(BANK_W), .COL_W(COL_W), .BL(BL),
                .CL(CL), .T_WTR(T_WTR), .T_WR(T_WR)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_bank(wr_bank), .wr_col(wr_col), .wr_ready(wr_ready),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_col(rd_col), .rd_ready(rd_ready),
    .pre_req(pre_req), .pre_bank(pre_bank), .pre_ready(pre_ready),
    .wd_data(wd_data), .wd_take(wd_take), .wd_beat(wd_beat),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .dq_out(dq_out), .dq_oe(dq_oe), .dm(dm)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int b);
    return 32'hC0DE_0000 | 32'(b);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  int c_cmd[NREL], c_oe[NREL], c_dm[NREL], c_wrr[NREL], c_rdr[NREL], c_prr[NREL];
  int c_bank[NREL], c_col[NREL];
  logic [31:0] c_data[NREL];

  // kind: 0 none, 1 read, 2 precharge same bank, 3 precharge other bank,
  //       4 read+precharge together, 5 write same bank, 6 write other bank
  task automatic run_case(int kind, int off);
    int n_oe, n_dm, last_oe, k, eb, sc, sc_rel, n_extra, e_oe, e_dm, e_sc, e_rel;
    string rq;
    n_oe = 0; n_dm = 0; last_oe = 0; k = 0; sc = 0; sc_rel = 0; n_extra = 0;
    @(negedge clk);
    wr_req = 1; wr_bank = 2'd1; wr_col = 8'h10;
    #1 chk(wr_ready == 1'b1, "R1", "wr_ready idle", int'(wr_ready), 1);
    @(posedge clk);
    for (int rel = 1; rel < NREL; rel++) begin
      @(negedge clk);
      wr_req = 0; rd_req = 0; pre_req = 0;
      if (rel == off + 1) begin
        case (kind)
          1: begin rd_req = 1; rd_bank = 2'd3; rd_col = 8'h55; end
          2: begin pre_req = 1; pre_bank = 2'd1; end
          3: begin pre_req = 1; pre_bank = 2'd0; end
          4: begin rd_req = 1; rd_bank = 2'd3; rd_col = 8'h55;
                   pre_req = 1; pre_bank = 2'd1; end
          5: begin wr_req = 1; wr_bank = 2'd1; wr_col = 8'h40; end
          6: begin wr_req = 1; wr_bank = 2'd2; wr_col = 8'h40; end
          default: ;
        endcase
      end
      #1;
      c_cmd[rel] = int'(cmd); c_oe[rel] = int'(dq_oe); c_dm[rel] = int'(dm == 4'hF);
      c_wrr[rel] = int'(wr_ready); c_rdr[rel] = int'(rd_ready);
      c_prr[rel] = int'(pre_ready); c_bank[rel] = int'(cmd_bank);
      c_col[rel] = int'(cmd_col); c_data[rel] = dq_out;
    end
    wr_req = 0; rd_req = 0; pre_req = 0;

    rq = (kind == 0) ? "R2" : (kind == 1) ? "R3" : (kind == 2) ? "R6" :
         (kind == 3) ? "R7" : (kind == 4) ? "R10" : "R9";
    case (kind)
      1, 4: begin e_oe = off; e_dm = BL - off; e_sc = 2; e_rel = off + T_WTR + 2; end
      2:    begin e_oe = off; e_dm = BL - off; e_sc = 3; e_rel = off + T_WR + 2; end
      5:    begin e_oe = off + BL; e_dm = 0; e_sc = 1; e_rel = off + 2; end
      default: begin e_oe = BL; e_dm = 0; e_sc = 0; e_rel = 0; end
    endcase

    chk(c_cmd[1] == 1, "R1", "WRITE cycle after accept", c_cmd[1], 1);
    chk(c_bank[1] == 1 && c_col[1] == 16, "R1", "WRITE column", c_col[1], 16);
    for (int rel = 2; rel < NREL; rel++) begin
      if (c_oe[rel] != 0) begin
        eb = (kind == 5 && k >= off) ? k - off : k;
        chk(c_data[rel] == pat(eb), "R1", "beat data", int'(c_data[rel][15:0]), eb);
        n_oe++; k++; last_oe = rel;
      end
      if (c_dm[rel] != 0) n_dm++;
      if (c_cmd[rel] != 0) begin
        n_extra++;
        if (sc_rel == 0) begin sc_rel = rel; sc = c_cmd[rel]; end
      end
    end
    chk(n_oe == e_oe, rq, "driven beats", n_oe, e_oe);
    chk(n_dm == e_dm, rq, "masked beats", n_dm, e_dm);
    chk(sc == e_sc, rq, "second command code", sc, e_sc);
    chk(n_extra == ((e_sc != 0) ? 1 : 0), rq, "command count", n_extra, (e_sc != 0) ? 1 : 0);
    if (e_sc != 0)
      chk(sc_rel == e_rel, (kind == 2) ? "R6" : (kind == 5) ? "R9" : "R4",
          "command cycle", sc_rel, e_rel);

    case (kind)
      1: chk(c_rdr[off + 1] == 1, "R3", "rd_ready in burst", c_rdr[off + 1], 1);
      2: chk(c_prr[off + 1] == 1, "R6", "pre_ready same bank", c_prr[off + 1], 1);
      3: chk(c_prr[off + 1] == 0, "R7", "pre_ready other bank", c_prr[off + 1], 0);
      4: chk(c_prr[off + 1] == 0, "R10", "pre_ready loses to read", c_prr[off + 1], 0);
      5: chk(c_wrr[off + 1] == 1, "R9", "wr_ready same bank", c_wrr[off + 1], 1);
      6: chk(c_wrr[off + 1] == 0, "R9", "wr_ready other bank", c_wrr[off + 1], 0);
      default: ;
    endcase

    if (kind == 1 || kind == 4) begin
      chk(c_bank[e_rel] == 3 && c_col[e_rel] == 85, "R4", "READ column", c_col[e_rel], 85);
      chk(last_oe <= e_rel + CL - 2, "R5", "last driven beat vs read data", last_oe, e_rel + CL - 2);
      chk(c_oe[e_rel] == 0 && c_oe[e_rel + 1] == 0, "R5", "bus off after READ", c_oe[e_rel + 1], 0);
      if (off < BL)
        chk(c_rdr[off + 2] == 0 && c_wrr[off + 2] == 0, "R8", "stall while pending",
            c_wrr[off + 2], 0);
      chk(c_wrr[e_rel + CL + BL - 2] == 0, "R8", "wr_ready during read data",
          c_wrr[e_rel + CL + BL - 2], 0);
      chk(c_wrr[e_rel + CL + BL - 1] == 1, "R8", "wr_ready after read data",
          c_wrr[e_rel + CL + BL - 1], 1);
    end
    if (kind == 2)
      chk(c_bank[e_rel] == 1, "R6", "PRECHARGE bank", c_bank[e_rel], 1);
    chk(c_oe[NREL-1] == 0 && c_dm[NREL-1] == 0 && c_wrr[NREL-1] == 1, "R2",
        "idle after burst", c_oe[NREL-1], 0);
  endtask

  // {kind[1:0], offset[3:0]}
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 4'd0}, {2'd1, 4'd0}, {2'd1, 4'd3}, {2'd1, 4'd8},
    {2'd2, 4'd2}, {2'd2, 4'd7}, {2'd3, 4'd4}, {2'd1, 4'd5}
  };

  initial begin
    // R11: reset state
    #5;
    chk(cmd == 2'b00, "R11", "cmd in reset", int'(cmd), 0);
    chk(dq_oe == 0 && dm == 0, "R11", "bus in reset", int'(dq_oe), 0);
    chk(wr_ready == 1 && rd_ready == 0 && pre_ready == 0, "R11", "readies in reset",
        int'(rd_ready), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int v = 0; v < 8; v++)
      run_case(int'(VEC[v][5:4]), int'(VEC[v][3:0]));

    run_case(4, 2);   // R10 collision of read and precharge
    run_case(5, 3);   // R9 restart on the open bank
    run_case(6, 3);   // R9 other bank refused

    // R11: reset in the middle of a burst
    @(negedge clk);
    wr_req = 1; wr_bank = 2'd1; wr_col = 8'h20;
    @(negedge clk); wr_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    #1;
    chk(dq_oe == 0 && dm == 0 && cmd == 2'b00, "R11", "burst cleared by reset",
        int'(dq_oe), 0);
    chk(wr_ready == 1 && rd_ready == 0, "R11", "readies after mid reset", int'(rd_ready), 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule